// File: doc/BRIEF.md
# Extended Index/Data Register File

This block holds the extended part of two indexed register banks of a display controller: a sequencer bank and a controller bank. Software reaches both through the same scheme. It first writes an index, then reads or writes the data location that index selects. Each bank keeps its own index register. One bank-select input picks which bank every access addresses.

Sequencer indices that fall in the extended window are stored locally. A stored write raises a one-cycle request to recompute display timing. Which indices are stored, how an index folds onto a storage slot and which writes raise the request all depend on a chip-variant strap. The strap is sampled once after reset.

Reads follow a fixed priority. A read returns one of these:
- a synthesized constant;
- a field mixed from stored bits and live inputs, namely the current bank number and a memory-address extension;
- a filtered copy of another stored register;
- plain storage;
- data from the external standard bank.

Any access that is not absorbed here goes to the external standard bank. For such accesses the block flags a write pulse or a read hit, and it presents the current index to that bank.

Top module: `ixr_regfile`

## Requirements
- R1: Both index registers reset to 0. An index write loads all 8 bits into the index register of the bank selected by `bank_sel_i` (0 = sequencer, 1 = controller). `std_idx_o` shows the index of the selected bank. Data accesses use the selected bank's current index.
- R2: The variant strap `newer_i` is captured on the first clock after reset is released (1 = newer variant). Later changes on `newer_i` have no effect until the next reset.
- R3: Newer variant: a sequencer data write at any index of 0x10 or above is stored in slot (index & 0x1F), and `recalc_o` is high for the one cycle that follows it. A write below 0x10 is not stored, raises `std_we_o` and does not raise `recalc_o`.
- R4: Older variant: only sequencer indices 0x10 to 0x1F are stored, into slot (index & 0x1F). Other indices raise `std_we_o`. `recalc_o` follows only writes to index 0x12 or 0x13.
- R5: Newer variant, sequencer read:
  - index 8 or above returns slot (index & 0x1F);
  - indices 0 to 4 return `std_rdata_i` with `std_hit_o` high;
  - indices 5 to 7 return 0xFF.
- R6: Older variant, sequencer read: indices 0x10 to 0x1F return their slot. Every other index returns `std_rdata_i` with `std_hit_o` high.
- R7: Controller index 0x2F reads 0x40 on the newer variant and 0x00 on the older one. It does not raise `std_hit_o`.
- R8: Controller index 0x6B reads stored register 0x59 with bits 1:0 cleared on the newer variant, and register 0x59 unchanged on the older one.
- R9: Controller index 0x6C reads 0x00 on the newer variant. On the older variant it reads bit 7 of stored register 0x5A, with all other bits 0.
- R10: Controller index 0x35 reads the stored bits 7:4 above `bank_num_i` in bits 3:0.
- R11: Controller index 0x31 reads the stored value ANDed with 0xCF, with `ma_ext_i` placed in bits 5:4.
- R12: Controller indices 0x30 to 0x6F are stored and read back unchanged, apart from the special indices above. Every other controller index passes both writes (`std_we_o`) and reads (`std_hit_o`, `std_rdata_i`) to the standard bank. Controller writes never raise `recalc_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| newer_i | input | 1 | Chip-variant strap, 1 = newer variant |
| bank_sel_i | input | 1 | Bank for this access: 0 sequencer, 1 controller |
| idx_we_i | input | 1 | Load `wdata_i` into the selected bank's index |
| dat_we_i | input | 1 | Write `wdata_i` at the selected bank's index |
| wdata_i | input | 8 | Index or data write value |
| rdata_o | output | 8 | Read value at the selected bank's index |
| bank_num_i | input | 4 | Current bank number, merged into index 0x35 |
| ma_ext_i | input | 2 | Memory-address extension, merged into index 0x31 |
| std_rdata_i | input | 8 | Read value from the external standard bank |
| std_hit_o | output | 1 | Read at the current index is served by the standard bank |
| std_we_o | output | 1 | Data write is passed to the standard bank |
| std_idx_o | output | 8 | Current index of the selected bank |
| recalc_o | output | 1 | One-cycle timing recalculation request |

## Verification
On the newer variant, sequencer slots 8 to 15 cannot be written at their own index, because writes below 0x10 go to the standard bank. They fill only through the folded indices 0x28 to 0x2F and 0x48 onward. The bench therefore writes all 256 sequencer indices with distinct values before it reads any of them back, and it keeps a model of which write landed last in each folded slot. Ignoring the strap after capture is shown by toggling `newer_i` in mid-run and reading back the variant-dependent constant at controller index 0x2F.

// File: rtl/ixr_pkg.sv
package ixr_pkg;
  localparam int unsigned DW = 8;
  localparam logic [DW-1:0] SEQ_EXT_LO  = 8'h10;
  localparam logic [DW-1:0] SEQ_OLD_HI  = 8'h1F;
  localparam logic [DW-1:0] SEQ_RSV_LO  = 8'h05;
  localparam logic [DW-1:0] SEQ_RSV_HI  = 8'h07;
  localparam logic [DW-1:0] SEQ_OLD_RC0 = 8'h12;
  localparam logic [DW-1:0] SEQ_OLD_RC1 = 8'h13;
  localparam logic [DW-1:0] CTL_REV     = 8'h2F;
  localparam logic [DW-1:0] CTL_MAEXT   = 8'h31;
  localparam logic [DW-1:0] CTL_BANK    = 8'h35;
  localparam logic [DW-1:0] CTL_MIR_HI  = 8'h6B;
  localparam logic [DW-1:0] CTL_MIR_LO  = 8'h6C;
  localparam logic [DW-1:0] CTL_SRC_HI  = 8'h59;
  localparam logic [DW-1:0] CTL_SRC_LO  = 8'h5A;
  localparam logic [DW-1:0] REV_NEWER   = 8'h40;
  typedef enum logic {BANK_SEQ = 1'b0, BANK_CTL = 1'b1} bank_e;
endpackage

// File: rtl/ixr_seq_bank.sv
module ixr_seq_bank
  import ixr_pkg::*;
#(
  parameter int unsigned SLOTS = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          newer_i,
  input  logic [DW-1:0] idx_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] std_rdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          std_hit_o,
  output logic          std_we_o,
  output logic          recalc_o
);
  localparam int unsigned SW = $clog2(SLOTS);

  logic [DW-1:0] mem [SLOTS];
  logic [SW-1:0] slot;
  logic          store_en, strobe_hit, old_rng;
  logic          recalc_q;

  assign slot     = idx_i[SW-1:0];
  assign old_rng  = (idx_i >= SEQ_EXT_LO) && (idx_i <= SEQ_OLD_HI);
  assign store_en = newer_i ? (idx_i >= SEQ_EXT_LO) : old_rng;
  assign strobe_hit = newer_i ? store_en
                              : (idx_i == SEQ_OLD_RC0 || idx_i == SEQ_OLD_RC1);
  assign std_we_o = we_i && !store_en;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   mem[s] <= '0;
      else if (we_i && store_en && slot == SW'(s))   mem[s] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) recalc_q <= 1'b0;
    else         recalc_q <= we_i && strobe_hit;
  end
  assign recalc_o = recalc_q;

  always_comb begin
    rdata_o   = std_rdata_i;
    std_hit_o = 1'b1;
    if (newer_i) begin
      if (idx_i >= 8'h08) begin
        rdata_o   = mem[slot];
        std_hit_o = 1'b0;
      end else if (idx_i >= SEQ_RSV_LO && idx_i <= SEQ_RSV_HI) begin
        rdata_o   = 8'hFF;
        std_hit_o = 1'b0;
      end
    end else if (old_rng) begin
      rdata_o   = mem[slot];
      std_hit_o = 1'b0;
    end
  end

  // R3/R4: strobe only follows an absorbed data write
  a_r3_strobe_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recalc_o |-> ($past(we_i) && !$past(std_we_o)));
  a_r4_old_strobe_idx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (recalc_o && !newer_i) |-> ($past(idx_i) == SEQ_OLD_RC0 || $past(idx_i) == SEQ_OLD_RC1));
  // R3: stored write reads back at the same index
  a_r3_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(we_i) && !$past(std_we_o) && idx_i == $past(idx_i) && newer_i == $past(newer_i))
      |-> (rdata_o == $past(wdata_i)));
  // R5: reserved indices never reach the standard bank
  a_r5_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (newer_i && idx_i >= SEQ_RSV_LO && idx_i <= SEQ_RSV_HI) |-> (!std_hit_o && rdata_o == 8'hFF));
endmodule

// File: rtl/ixr_ctl_bank.sv
module ixr_ctl_bank
  import ixr_pkg::*;
#(
  parameter int unsigned LO   = 'h30,
  parameter int unsigned SIZE = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          newer_i,
  input  logic [DW-1:0] idx_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] std_rdata_i,
  input  logic [3:0]    bank_num_i,
  input  logic [1:0]    ma_ext_i,
  output logic [DW-1:0] rdata_o,
  output logic          std_hit_o,
  output logic          std_we_o
);
  localparam int unsigned O_MAEXT  = int'(CTL_MAEXT)  - LO;
  localparam int unsigned O_BANK   = int'(CTL_BANK)   - LO;
  localparam int unsigned O_SRC_HI = int'(CTL_SRC_HI) - LO;
  localparam int unsigned O_SRC_LO = int'(CTL_SRC_LO) - LO;

  logic [DW-1:0] mem [SIZE];
  logic [DW-1:0] stored;
  logic          in_rng;

  assign in_rng   = (int'(idx_i) >= LO) && (int'(idx_i) < LO + SIZE);
  assign std_we_o = we_i && !in_rng;

  for (genvar e = 0; e < SIZE; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               mem[e] <= '0;
      else if (we_i && int'(idx_i) == LO + e)    mem[e] <= wdata_i;
    end
  end

  always_comb begin
    stored = '0;
    for (int e = 0; e < SIZE; e++)
      if (int'(idx_i) == LO + e) stored = mem[e];
  end

  always_comb begin
    std_hit_o = 1'b0;
    unique case (idx_i)
      CTL_REV:    rdata_o = newer_i ? REV_NEWER : 8'h00;
      CTL_MAEXT:  rdata_o = (mem[O_MAEXT] & 8'hCF) | {2'b00, ma_ext_i, 4'h0};
      CTL_BANK:   rdata_o = {mem[O_BANK][7:4], bank_num_i};
      CTL_MIR_HI: rdata_o = newer_i ? (mem[O_SRC_HI] & 8'hFC) : mem[O_SRC_HI];
      CTL_MIR_LO: rdata_o = newer_i ? 8'h00 : {mem[O_SRC_LO][7], 7'h00};
      default: begin
        if (in_rng) rdata_o = stored;
        else begin
          rdata_o   = std_rdata_i;
          std_hit_o = 1'b1;
        end
      end
    endcase
  end

  // R10: stored nibble survives, bank number follows live input
  a_r10_bank_nibble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(we_i) && $past(idx_i) == CTL_BANK && idx_i == CTL_BANK)
      |-> (rdata_o == {$past(wdata_i[7:4]), bank_num_i}));
  // R12: plain stored locations read back the last write
  a_r12_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(we_i) && !$past(std_we_o) && idx_i == $past(idx_i) && idx_i != CTL_MAEXT
     && idx_i != CTL_BANK && idx_i != CTL_MIR_HI && idx_i != CTL_MIR_LO)
      |-> (rdata_o == $past(wdata_i)));
  // R9: newer-variant mirror is constant zero
  a_r9_mirror_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (newer_i && idx_i == CTL_MIR_LO) |-> (rdata_o == 8'h00 && !std_hit_o));
  // R7: revision index never reaches the standard bank
  a_r7_rev_local: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_i == CTL_REV) |-> !std_hit_o);
endmodule

// File: rtl/ixr_regfile.sv
module ixr_regfile
  import ixr_pkg::*;
#(
  parameter int unsigned SEQ_SLOTS = 32,
  parameter int unsigned CTL_LO    = 'h30,
  parameter int unsigned CTL_SIZE  = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          newer_i,
  input  logic          bank_sel_i,
  input  logic          idx_we_i,
  input  logic          dat_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [3:0]    bank_num_i,
  input  logic [1:0]    ma_ext_i,
  input  logic [DW-1:0] std_rdata_i,
  output logic          std_hit_o,
  output logic          std_we_o,
  output logic [DW-1:0] std_idx_o,
  output logic          recalc_o
);
  bank_e         bank;
  logic [DW-1:0] seq_idx_q, ctl_idx_q;
  logic          strap_done_q, variant_q;
  logic [DW-1:0] seq_rd, ctl_rd;
  logic          seq_hit, ctl_hit, seq_we, ctl_we;

  assign bank = bank_e'(bank_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_done_q <= 1'b0;
      variant_q    <= 1'b0;
    end else if (!strap_done_q) begin
      strap_done_q <= 1'b1;
      variant_q    <= newer_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_idx_q <= '0;
      ctl_idx_q <= '0;
    end else if (idx_we_i) begin
      if (bank == BANK_CTL) ctl_idx_q <= wdata_i;
      else                  seq_idx_q <= wdata_i;
    end
  end

  ixr_seq_bank #(.SLOTS(SEQ_SLOTS)) i_seq (
    .clk_i, .rst_ni,
    .newer_i     (variant_q),
    .idx_i       (seq_idx_q),
    .we_i        (dat_we_i && bank == BANK_SEQ),
    .wdata_i,
    .std_rdata_i,
    .rdata_o     (seq_rd),
    .std_hit_o   (seq_hit),
    .std_we_o    (seq_we),
    .recalc_o
  );

  ixr_ctl_bank #(.LO(CTL_LO), .SIZE(CTL_SIZE)) i_ctl (
    .clk_i, .rst_ni,
    .newer_i     (variant_q),
    .idx_i       (ctl_idx_q),
    .we_i        (dat_we_i && bank == BANK_CTL),
    .wdata_i,
    .std_rdata_i,
    .bank_num_i,
    .ma_ext_i,
    .rdata_o     (ctl_rd),
    .std_hit_o   (ctl_hit),
    .std_we_o    (ctl_we)
  );

  assign rdata_o   = (bank == BANK_CTL) ? ctl_rd    : seq_rd;
  assign std_hit_o = (bank == BANK_CTL) ? ctl_hit   : seq_hit;
  assign std_idx_o = (bank == BANK_CTL) ? ctl_idx_q : seq_idx_q;
  assign std_we_o  = seq_we | ctl_we;

  // R2: strap frozen once captured
  a_r2_strap_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(strap_done_q) |-> $stable(variant_q));
  // R1: index registers move only on an index write
  a_r1_idx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(idx_we_i) |-> ($stable(seq_idx_q) && $stable(ctl_idx_q)));
  // R12: controller writes never request recalculation
  a_r12_ctl_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(dat_we_i) && $past(bank_sel_i)) |-> !recalc_o);
endmodule

// File: tb/test_ixr_regfile.sv
module test_ixr_regfile;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       newer_i = 1'b0;
  logic       bank_sel_i = 1'b0;
  logic       idx_we_i = 1'b0;
  logic       dat_we_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [3:0] bank_num_i = '0;
  logic [1:0] ma_ext_i = '0;
  logic [7:0] std_rdata_i = '0;
  logic       std_hit_o, std_we_o, recalc_o;
  logic [7:0] std_idx_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [7:0] seq_m [32];
  logic [7:0] ctl_m [256];

  always #2 clk = ~clk;

  ixr_regfile i_ixr_regfile (
    .clk_i(clk), .rst_ni, .newer_i, .bank_sel_i, .idx_we_i, .dat_we_i,
    .wdata_i, .rdata_o, .bank_num_i, .ma_ext_i, .std_rdata_i,
    .std_hit_o, .std_we_o, .std_idx_o, .recalc_o
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(bit nv);
    @(negedge clk);
    rst_ni = 1'b0; newer_i = nv;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 32; k++) seq_m[k] = '0;
    for (int k = 0; k < 256; k++) ctl_m[k] = '0;
    bank_sel_i = 1'b0; #1;
    chk("R1 seq idx reset", std_idx_o, 8'h00);
    chk("R1 recalc reset", {7'b0, recalc_o}, 8'h00);
    bank_sel_i = 1'b1; #1;
    chk("R1 ctl idx reset", std_idx_o, 8'h00);
  endtask

  task automatic set_idx(bit b, logic [7:0] v);
    @(negedge clk);
    bank_sel_i = b; idx_we_i = 1'b1; wdata_i = v;
    @(negedge clk);
    idx_we_i = 1'b0;
    #1 chk("R1 index load", std_idx_o, v);
  endtask

  task automatic wr_dat(string req, bit b, logic [7:0] v, bit e_we, bit e_rc);
    @(negedge clk);
    bank_sel_i = b; dat_we_i = 1'b1; wdata_i = v;
    #1 chk({req, " std_we"}, {7'b0, std_we_o}, {7'b0, e_we});
    @(negedge clk);
    dat_we_i = 1'b0;
    chk({req, " recalc"}, {7'b0, recalc_o}, {7'b0, e_rc});
  endtask

  task automatic rd(string req, bit b, logic [7:0] e, bit e_hit);
    @(negedge clk);
    bank_sel_i = b;
    #1;
    chk({req, " data"}, rdata_o, e);
    chk({req, " std_hit"}, {7'b0, std_hit_o}, {7'b0, e_hit});
  endtask

  task automatic run_variant(bit nv);
    logic [7:0] v, e;
    bit st, hit;
    string tag;
    do_reset(nv);
    // sequencer writes over every index
    for (int i = 0; i < 256; i++) begin
      v  = 8'((i * 37 + 11) & 8'hFF);
      st = nv ? (i >= 16) : (i >= 16 && i <= 31);
      set_idx(1'b0, 8'(i));
      wr_dat(nv ? "R3" : "R4", 1'b0, v, !st, nv ? st : (i == 18 || i == 19));
      if (st) seq_m[i & 31] = v;
    end
    // sequencer reads
    for (int i = 0; i < 256; i++) begin
      set_idx(1'b0, 8'(i));
      std_rdata_i = ~8'(i);
      if (nv) begin
        if (i >= 8)      begin e = seq_m[i & 31]; hit = 0; end
        else if (i <= 4) begin e = ~8'(i);        hit = 1; end
        else             begin e = 8'hFF;         hit = 0; end
      end else begin
        if (i >= 16 && i <= 31) begin e = seq_m[i & 31]; hit = 0; end
        else                    begin e = ~8'(i);        hit = 1; end
      end
      rd(nv ? "R5" : "R6", 1'b0, e, hit);
    end
    // controller writes over every index
    for (int i = 0; i < 256; i++) begin
      v  = 8'((i * 53 + 7) & 8'hFF);
      st = (i >= 'h30 && i <= 'h6F);
      set_idx(1'b1, 8'(i));
      wr_dat("R12", 1'b1, v, !st, 1'b0);
      if (st) ctl_m[i] = v;
    end
    // controller reads
    for (int i = 0; i < 256; i++) begin
      set_idx(1'b1, 8'(i));
      std_rdata_i = ~8'(i);
      bank_num_i  = 4'(i) ^ 4'h9;
      ma_ext_i    = 2'(i >> 6) ^ 2'b10;
      st  = (i >= 'h30 && i <= 'h6F);
      hit = !st && (i != 'h2F);
      case (i)
        'h2F: begin tag = "R7";  e = nv ? 8'h40 : 8'h00; end
        'h31: begin tag = "R11"; e = (ctl_m[i] & 8'hCF) | {2'b00, ma_ext_i, 4'h0}; end
        'h35: begin tag = "R10"; e = {ctl_m[i][7:4], bank_num_i}; end
        'h6B: begin tag = "R8";  e = nv ? (ctl_m['h59] & 8'hFC) : ctl_m['h59]; end
        'h6C: begin tag = "R9";  e = nv ? 8'h00 : (ctl_m['h5A] & 8'h80); end
        default: begin tag = "R12"; e = st ? ctl_m[i] : ~8'(i); end
      endcase
      rd(tag, 1'b1, e, hit);
    end
    // strap change after capture is ignored
    @(negedge clk);
    newer_i = !nv;
    repeat (4) @(negedge clk);
    set_idx(1'b1, 8'h2F);
    rd("R2", 1'b1, nv ? 8'h40 : 8'h00, 1'b0);
    set_idx(1'b0, 8'h06);
    std_rdata_i = 8'h3C;
    rd("R2", 1'b0, nv ? 8'hFF : 8'h3C, !nv);
  endtask

  initial begin
    run_variant(1'b1);
    run_variant(1'b0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule